// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block models one storage cell of a programmable logic fabric. It takes a sum-of-products data term and returns a result on two outputs. One output feeds the internal interconnect. The other drives a device pin through an output polarity stage and an output enable. A set of configuration inputs sets the cell's behaviour:

- the storage element type: combinational pass-through, D flip-flop, T flip-flop or level-sensitive latch;
- which clock drives the element, and that clock's polarity;
- the polarity of two asynchronous product terms, one that sets the cell and one that clears it;
- whether the element takes its data from a neighbouring cell's pin instead of the sum-of-products term;
- the polarity of the pin output.

Everything runs on a single system clock. The four global clocks and the product-term clock are sampled strobes in that clock domain. An active edge is seen when the selected clock, after its polarity is applied, is high in the current system cycle and was low in the previous system cycle. The cell's own pin input comes back unchanged on a separate output. A cell whose result is used only internally can therefore still serve its pin as an input.

Top module: `mc_reg_cell`

## Requirements
- R1: With `cfg_mode`=00 (combinational), `fb_out` equals the selected data input in the same cycle, and no clock is needed.
- R2: With `cfg_mode`=01 (D), the stored value takes the selected data input on each system clock edge at which an active edge of the selected clock is seen. It holds at all other edges. `fb_out` shows the stored value.
- R3: With `cfg_mode`=10 (T), the stored value inverts on an active clock edge when the data input is 1. It holds when the data input is 0, and it holds when there is no active edge.
- R4: With `cfg_mode`=11 (latch), `fb_out` follows the data input while the selected clock is at its active level. While the clock is inactive, `fb_out` keeps the value from the last system cycle.
- R5: `cfg_clk_sel` values 0 to 3 pick `gclk[0]` to `gclk[3]`, and value 4 picks `pt_clk`. Values 5 to 7 disable the clock: the clock never gives an edge and the latch stays closed.
- R6: With `cfg_clk_inv`=1, the selected clock is inverted before edge and level detection. The element then captures on the falling edge, and the latch is open while the clock is low.
- R7: The clear term, when active, forces `fb_out` to 0 at once and the stored value to 0. The set term, when active, forces 1 in the same way. When both are active, the clear term wins.
- R8: The clear term is active when `rst_pt` XOR `cfg_rst_inv` is 1. The set term is active when `set_pt` XOR `cfg_set_inv` is 1.
- R9: With `cfg_in_reg`=1, the data input is `nbr_pin_in`. With `cfg_in_reg`=0, the data input is `sop_in`.
- R10: `pin_out` equals `fb_out` XOR `cfg_out_inv`, and `pin_oe` equals `oe_in`, in every mode.
- R11: `pin_in_fb` equals `pin_in` in the same cycle, whatever the configuration.
- R12: While `rst_n` is low, the stored value is 0 and the clock history is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop_in | input | 1 | Sum-of-products data term |
| nbr_pin_in | input | 1 | Pin input of the neighbouring cell |
| pin_in | input | 1 | This cell's own pin input |
| set_pt | input | 1 | Asynchronous set product term |
| rst_pt | input | 1 | Asynchronous clear product term |
| gclk | input | GCLK_N (4) | Global clock strobes |
| pt_clk | input | 1 | Product-term clock strobe |
| cfg_mode | input | 2 | Storage type: 00 comb, 01 D, 10 T, 11 latch |
| cfg_clk_sel | input | SEL_W (3) | Clock source select |
| cfg_clk_inv | input | 1 | Clock polarity invert |
| cfg_set_inv | input | 1 | Set term polarity invert |
| cfg_rst_inv | input | 1 | Clear term polarity invert |
| cfg_in_reg | input | 1 | Input-register mode: data from neighbour pin |
| cfg_out_inv | input | 1 | Pin output polarity invert |
| oe_in | input | 1 | Pin output enable request |
| fb_out | output | 1 | Result to the interconnect |
| pin_out | output | 1 | Pin data after the polarity stage |
| pin_oe | output | 1 | Pin output enable |
| pin_in_fb | output | 1 | Pin input passed to the interconnect |

## Verification
Each storage type is driven with random data against random clock strobes on a fixed clock source. This separates edge capture from level transparency, and it shows whether a toggle depends on the data bit. The clock-select sweep and the inverted-clock runs check that only the chosen strobe matters, that codes 5 to 7 freeze a D cell and close a latch, and that the falling edge becomes the capture point. Random set and clear terms, first with plain and then with inverted polarity, show both the immediate override and the clear-over-set priority. A final mixed run randomizes every configuration field together, to catch interactions between data source, output polarity and mode.

// File: rtl/mc_reg_cell.sv
module mc_reg_cell #(
  parameter int GCLK_N = 4,
  parameter int SEL_W  = $clog2(GCLK_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_in,
  input  logic              nbr_pin_in,
  input  logic              pin_in,
  input  logic              set_pt,
  input  logic              rst_pt,
  input  logic [GCLK_N-1:0] gclk,
  input  logic              pt_clk,
  input  logic [1:0]        cfg_mode,
  input  logic [SEL_W-1:0]  cfg_clk_sel,
  input  logic              cfg_clk_inv,
  input  logic              cfg_set_inv,
  input  logic              cfg_rst_inv,
  input  logic              cfg_in_reg,
  input  logic              cfg_out_inv,
  input  logic              oe_in,
  output logic              fb_out,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              pin_in_fb
);

  typedef enum logic [1:0] {M_COMB = 2'd0, M_D = 2'd1, M_T = 2'd2, M_LAT = 2'd3} mode_e;

  mode_e mode;
  logic  raw_clk, clk_ok, clk_lvl, clk_prev, clk_edge;
  logic  d_src, set_a, clr_a, q, core, q_nxt;

  assign mode = mode_e'(cfg_mode);

  always_comb begin
    raw_clk = 1'b0;
    clk_ok  = 1'b0;
    for (int i = 0; i < GCLK_N; i++) begin
      if (cfg_clk_sel == SEL_W'(i)) begin
        raw_clk = gclk[i];
        clk_ok  = 1'b1;
      end
    end
    if (cfg_clk_sel == SEL_W'(GCLK_N)) begin
      raw_clk = pt_clk;
      clk_ok  = 1'b1;
    end
  end

  assign clk_lvl  = clk_ok & (raw_clk ^ cfg_clk_inv);
  assign clk_edge = clk_lvl & ~clk_prev;
  assign d_src    = cfg_in_reg ? nbr_pin_in : sop_in;
  assign set_a    = set_pt ^ cfg_set_inv;
  assign clr_a    = rst_pt ^ cfg_rst_inv;

  always_comb begin
    case (mode)
      M_COMB:  begin core = d_src;                    q_nxt = d_src; end
      M_D:     begin core = q;                        q_nxt = clk_edge ? d_src : q; end
      M_T:     begin core = q;                        q_nxt = clk_edge ? (q ^ d_src) : q; end
      M_LAT:   begin core = clk_lvl ? d_src : q;      q_nxt = core; end
      default: begin core = q;                        q_nxt = q; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= 1'b0;
      clk_prev <= 1'b0;
    end else begin
      q        <= clr_a ? 1'b0 : (set_a ? 1'b1 : q_nxt);
      clk_prev <= clk_lvl;
    end
  end

  assign fb_out    = clr_a ? 1'b0 : (set_a ? 1'b1 : core);
  assign pin_out   = fb_out ^ cfg_out_inv;
  assign pin_oe    = oe_in;
  assign pin_in_fb = pin_in;

endmodule

// File: rtl/mc_reg_cell_chk.sv
module mc_reg_cell_chk #(
  parameter int GCLK_N = 4,
  parameter int SEL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sop_in,
  input logic             nbr_pin_in,
  input logic             pin_in,
  input logic             set_pt,
  input logic             rst_pt,
  input logic [1:0]       cfg_mode,
  input logic [SEL_W-1:0] cfg_clk_sel,
  input logic             cfg_set_inv,
  input logic             cfg_rst_inv,
  input logic             cfg_in_reg,
  input logic             cfg_out_inv,
  input logic             fb_out,
  input logic             pin_out,
  input logic             pin_in_fb
);

  logic clr_on, set_on, quiet, clk_off;
  assign clr_on  = rst_pt ^ cfg_rst_inv;
  assign set_on  = set_pt ^ cfg_set_inv;
  assign quiet   = !clr_on && !set_on;
  assign clk_off = cfg_clk_sel > SEL_W'(GCLK_N);

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_on |-> !fb_out);

  assert_set_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_on && !clr_on) |-> fb_out);

  assert_pin_polarity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out == (fb_out ^ cfg_out_inv));

  assert_pin_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pin_in_fb == pin_in);

  assert_comb_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00 && quiet) |-> fb_out == (cfg_in_reg ? nbr_pin_in : sop_in));

  assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && $past(cfg_mode) == 2'b01 && clk_off && quiet &&
     $past(quiet) && $past(clk_off) && $past(rst_n)) |-> $stable(fb_out));

endmodule

bind mc_reg_cell mc_reg_cell_chk #(.GCLK_N(GCLK_N), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sop_in(sop_in), .nbr_pin_in(nbr_pin_in),
  .pin_in(pin_in), .set_pt(set_pt), .rst_pt(rst_pt), .cfg_mode(cfg_mode),
  .cfg_clk_sel(cfg_clk_sel), .cfg_set_inv(cfg_set_inv), .cfg_rst_inv(cfg_rst_inv),
  .cfg_in_reg(cfg_in_reg), .cfg_out_inv(cfg_out_inv), .fb_out(fb_out),
  .pin_out(pin_out), .pin_in_fb(pin_in_fb));

// File: tb/mc_reg_cell_tb.sv
module mc_reg_cell_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop = 0, nbr = 0, pin = 0, setpt = 0, rstpt = 0, ptclk = 0;
  logic [3:0] gclk = '0;
  logic [1:0] mode = 2'b01;
  logic [2:0] sel = 3'd7;
  logic cinv = 0, sinv = 0, rinv = 0, inreg = 0, oinv = 0, oe = 0;
  logic fb, pout, poe, pinfb;

  int n_chk = 0, n_bad = 0;
  string req = "R12";
  logic mq = 0, mprev = 0;

  always #5 clk = ~clk;

  mc_reg_cell u_dut (
    .clk(clk), .rst_n(rst_n), .sop_in(sop), .nbr_pin_in(nbr), .pin_in(pin),
    .set_pt(setpt), .rst_pt(rstpt), .gclk(gclk), .pt_clk(ptclk),
    .cfg_mode(mode), .cfg_clk_sel(sel), .cfg_clk_inv(cinv), .cfg_set_inv(sinv),
    .cfg_rst_inv(rinv), .cfg_in_reg(inreg), .cfg_out_inv(oinv), .oe_in(oe),
    .fb_out(fb), .pin_out(pout), .pin_oe(poe), .pin_in_fb(pinfb));

  task automatic chk(string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One system cycle: compare outputs against the model, then advance the model at the edge.
  task automatic tick();
    logic raw, ok, lvl, d, s, r, core, nxt, e;
    #1;
    ok = 1'b1;
    if (sel < 4) raw = gclk[sel];
    else if (sel == 4) raw = ptclk;
    else begin raw = 1'b0; ok = 1'b0; end
    lvl = ok ? (raw ^ cinv) : 1'b0;          // R5 R6
    d = inreg ? nbr : sop;                   // R9
    s = setpt ^ sinv;                        // R8
    r = rstpt ^ rinv;
    case (mode)
      2'b00: begin core = d; nxt = d; end                                 // R1
      2'b01: begin core = mq; nxt = (lvl && !mprev) ? d : mq; end          // R2
      2'b10: begin core = mq; nxt = (lvl && !mprev) ? (mq ^ d) : mq; end   // R3
      default: begin core = lvl ? d : mq; nxt = core; end                  // R4
    endcase
    e = r ? 1'b0 : (s ? 1'b1 : core);        // R7
    chk("fb_out", fb, e);
    chk("pin_out", pout, e ^ oinv);          // R10
    chk("pin_oe", poe, oe);
    chk("pin_in_fb", pinfb, pin);            // R11
    @(posedge clk);
    if (!rst_n) begin mq = 1'b0; mprev = 1'b0; end   // R12
    else begin mq = r ? 1'b0 : (s ? 1'b1 : nxt); mprev = lvl; end
    @(negedge clk);
  endtask

  task automatic rnd_data();
    sop = 1'($urandom); nbr = 1'($urandom); pin = 1'($urandom);
    gclk = 4'($urandom); ptclk = 1'($urandom);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin rnd_data(); tick(); end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R12"; mode = 2'b01; sel = 3'd0;
    run(4);
    rst_n = 1'b1;
    req = "R1";  mode = 2'b00; sel = 3'd7; run(12);
    req = "R2";  mode = 2'b01; sel = 3'd0; run(32);
    req = "R3";  mode = 2'b10; sel = 3'd2; run(32);
    req = "R4";  mode = 2'b11; sel = 3'd1; run(32);
    req = "R5";  mode = 2'b01; sel = 3'd3; run(20);
    sel = 3'd4; run(20);
    sel = 3'd6; run(16);
    mode = 2'b11; sel = 3'd5; run(16);
    mode = 2'b10; sel = 3'd7; run(16);
    req = "R6";  cinv = 1; mode = 2'b01; sel = 3'd0; run(24);
    mode = 2'b11; run(24);
    mode = 2'b10; sel = 3'd4; run(24);
    cinv = 0;
    req = "R7";  mode = 2'b01; sel = 3'd0;
    for (int i = 0; i < 32; i++) begin
      setpt = 1'($urandom); rstpt = 1'($urandom); rnd_data(); tick();
    end
    req = "R8";
    for (int i = 0; i < 32; i++) begin
      setpt = 1'($urandom); rstpt = 1'($urandom);
      sinv = 1'($urandom); rinv = 1'($urandom); rnd_data(); tick();
    end
    setpt = 0; rstpt = 0; sinv = 0; rinv = 0;
    req = "R9";  inreg = 1; mode = 2'b01; sel = 3'd1; run(20);
    mode = 2'b00; run(12);
    mode = 2'b11; run(12);
    inreg = 0;
    req = "R10";
    for (int i = 0; i < 24; i++) begin
      oinv = 1'($urandom); oe = 1'($urandom); mode = 2'($urandom); rnd_data(); tick();
    end
    req = "R11";
    for (int i = 0; i < 16; i++) begin
      mode = 2'($urandom); sel = 3'($urandom); rnd_data(); tick();
    end
    req = "mixed";
    for (int i = 0; i < 300; i++) begin
      mode = 2'($urandom); sel = 3'($urandom); cinv = 1'($urandom);
      inreg = 1'($urandom); oinv = 1'($urandom); oe = 1'($urandom);
      sinv = 1'($urandom); rinv = 1'($urandom);
      setpt = 1'(($urandom % 8) == 0) ^ sinv;
      rstpt = 1'(($urandom % 8) == 0) ^ rinv;
      rnd_data(); tick();
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule